// File: doc/BRIEF.md
# Analog Acquisition Trigger Controller

This block sits between a host register bus and an analog-to-digital converter on a 16-channel acquisition card. It decides when a conversion starts: on a software strobe written over the bus, on a tick from an external pacer timer, or on a rising edge of an external trigger pin. For each accepted trigger it requests one conversion from the converter and names the channel. On completion it packs the result into a 16-bit word and stores that word in a sample FIFO. The host drains the FIFO through the data address.

In autoscan mode the channel walks upward from 0 to a programmed limit and then wraps. With autoscan off, only the programmed channel is converted. A status word reports the input range code, three active-low FIFO flags and a converter-busy bit. Two sticky interrupt outputs each take their event from a selectable source. Bus writes are registered at the clock edge. Reads are combinational from the addressed state. A read of the data address pops the FIFO at that edge.

Top module: `acq_trig_ctrl`

## Requirements
- R1: After reset, status (address 0x4) reads 0x0060: range 0, busy 0, FIFO-not-empty bit 4 low, half and full flags high. Mode readback (address 0x6) reads 0, and both interrupt outputs are low.
- R2: Mode bit 2 set selects rising edges of `ext_trig` as the only trigger source. Otherwise, mode bit 1 set selects `pacer_tick` as the only source. With both bits clear, only a write to address 0xA triggers. Events from unselected sources start no conversion.
- R3: With mode bit 0 set, successive conversions use channels 0, 1, … up to the value written to address 0x2, then wrap to 0. A write to address 0x2 or 0x6 restarts the walk at 0.
- R4: With mode bit 0 clear, every conversion uses the channel written to address 0x2. Reading address 0x2 returns the next channel to be converted in bits 3:0.
- R5: `conv_req` is a one-cycle pulse. Status bit 7 is high from the request until `conv_done`. A trigger arriving while busy is ignored.
- R6: Status flags are active-low. Bit 4 is 0 when the FIFO is empty. Bit 5 is 0 when the FIFO holds 512 or more entries. Bit 6 is 0 when it holds 1024.
- R7: When the FIFO is full, further samples are dropped and bit 6 stays 0 until a read or a reset. Reads at address 0x0 return samples oldest first.
- R8: While interrupt-control bit 2 (address 0x8) is set, the FIFO is held empty and both interrupt outputs are cleared. Clearing the bit re-enables the FIFO.
- R9: With SAMPLE_W=16, the stored word equals the converter word unchanged (offset binary; software inverts bit 15 to get two's complement). With SAMPLE_W=12, the sample occupies bits 15:4 and bits 3:0 read 0.
- R10: Interrupt-control bit 0 clear sets `irq_slot0` on each completed conversion. Bit 0 set sets it when the FIFO reaches 512 entries.
- R11: Interrupt-control bit 1 clear sets `irq_slot1` on each `pacer_tick`. Bit 1 set sets it on each rising edge of `ext_trig`.
- R12: Both interrupt outputs hold once set. A write of any value to address 0xC clears both.
- R13: A write to address 0x4 stores a 3-bit range shown in status bits 2:0. Address 0x6 reads the 4-bit mode in bits 3:0, where bit 3 is the stored pretrigger enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the FIFO at address 0x0) |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| pacer_tick | input | 1 | One-cycle pacer timer tick |
| ext_trig | input | 1 | External trigger level |
| conv_req | output | 1 | Conversion request pulse |
| conv_chan | output | CH_W | Channel for the requested conversion |
| conv_done | input | 1 | Conversion complete pulse |
| conv_data | input | SAMPLE_W | Converter result |
| irq_slot0 | output | 1 | Sticky interrupt, slot 0 |
| irq_slot1 | output | 1 | Sticky interrupt, slot 1 |

## Verification
The channel sequencer is driven from a table of patterns. Each pattern tells a different behaviour apart:
- a mid-range scan limit shows the wrap;
- a limit of 0 shows the degenerate scan;
- the top channel shows the scan does not wrap early;
- autoscan off shows the fixed channel;
- a limit of 1 shows the shortest alternating scan.

Each trigger source is then fed events from all three sources, so a wrongly selected source shows up as an extra or missing request. A fill of 1025 pacer-driven samples tells the 511/512 half-full step apart from the 1023/1024 full step. It also tells a dropped sample apart from an overwritten one, and both widths of sample packing are compared on the same conversion.

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl #(
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 1024,
  parameter int CH_W     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [3:0]          bus_addr,
  input  logic [15:0]         bus_wdata,
  output logic [15:0]         bus_rdata,
  input  logic                pacer_tick,
  input  logic                ext_trig,
  output logic                conv_req,
  output logic [CH_W-1:0]     conv_chan,
  input  logic                conv_done,
  input  logic [SAMPLE_W-1:0] conv_data,
  output logic                irq_slot0,
  output logic                irq_slot1
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_CNT = (AW+1)'(DEPTH/2);
  localparam logic [3:0] A_DATA = 4'h0, A_CHAN = 4'h2, A_RNG = 4'h4, A_MODE = 4'h6,
                         A_INTC = 4'h8, A_SWT = 4'hA, A_ICLR = 4'hC;

  logic [CH_W-1:0] chan_q, scan_q, cur_chan;
  logic [2:0]      rng_q, intc_q;
  logic [3:0]      mode_q;
  logic            busy_q, ext_q, hf_q;
  logic [15:0]     mem [DEPTH];
  logic [AW-1:0]   wp_q, rp_q;
  logic [AW:0]     cnt_q;
  logic [15:0]     word;

  wire wr_chan = bus_wr & (bus_addr == A_CHAN);
  wire wr_rng  = bus_wr & (bus_addr == A_RNG);
  wire wr_mode = bus_wr & (bus_addr == A_MODE);
  wire wr_intc = bus_wr & (bus_addr == A_INTC);
  wire wr_swt  = bus_wr & (bus_addr == A_SWT);
  wire wr_iclr = bus_wr & (bus_addr == A_ICLR);

  wire ext_edge = ext_trig & ~ext_q;
  wire trig     = mode_q[2] ? ext_edge : (mode_q[1] ? pacer_tick : wr_swt);
  wire start    = trig & ~busy_q;
  wire done     = conv_done & busy_q;
  wire fifo_clr = intc_q[2];
  wire full     = (cnt_q == FULL_CNT);
  wire hf       = (cnt_q >= HALF_CNT);
  wire push     = done & ~full & ~fifo_clr;
  wire pop      = bus_rd & (bus_addr == A_DATA) & (cnt_q != '0) & ~fifo_clr;
  wire ev0      = intc_q[0] ? (hf & ~hf_q) : done;
  wire ev1      = intc_q[1] ? ext_edge : pacer_tick;

  assign cur_chan = mode_q[0] ? scan_q : chan_q;

  generate
    if (SAMPLE_W >= 16) begin : g_wide
      assign word = conv_data[15:0];
    end else begin : g_narrow
      assign word = {conv_data, {(16-SAMPLE_W){1'b0}}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0; scan_q <= '0; rng_q <= '0; mode_q <= '0; intc_q <= '0;
      busy_q <= 1'b0; ext_q <= 1'b0; hf_q <= 1'b0;
      conv_req <= 1'b0; conv_chan <= '0;
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
      irq_slot0 <= 1'b0; irq_slot1 <= 1'b0;
    end else begin
      ext_q <= ext_trig;
      hf_q  <= hf;
      if (wr_chan) chan_q <= bus_wdata[CH_W-1:0];
      if (wr_rng)  rng_q  <= bus_wdata[2:0];
      if (wr_mode) mode_q <= bus_wdata[3:0];
      if (wr_intc) intc_q <= bus_wdata[2:0];
      if (wr_chan | wr_mode) scan_q <= '0;
      else if (start) scan_q <= (scan_q >= chan_q) ? '0 : scan_q + 1'b1;
      conv_req <= start;
      if (start) conv_chan <= cur_chan;
      if (start) busy_q <= 1'b1;
      else if (conv_done) busy_q <= 1'b0;
      if (fifo_clr) begin
        wp_q <= '0; rp_q <= '0; cnt_q <= '0;
      end else begin
        if (push) wp_q <= wp_q + 1'b1;
        if (pop)  rp_q <= rp_q + 1'b1;
        cnt_q <= cnt_q + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
      end
      if (wr_iclr | fifo_clr) begin
        irq_slot0 <= 1'b0; irq_slot1 <= 1'b0;
      end else begin
        if (ev0) irq_slot0 <= 1'b1;
        if (ev1) irq_slot1 <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= word;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DATA:  bus_rdata = mem[rp_q];
      A_CHAN:  bus_rdata[CH_W-1:0] = cur_chan;
      A_RNG:   bus_rdata = {8'h00, busy_q, ~full, ~hf, (cnt_q != '0), 1'b0, rng_q};
      A_MODE:  bus_rdata = {9'd0, intc_q, mode_q};
      default: bus_rdata = '0;
    endcase
  end
endmodule

module acq_trig_ctrl_chk #(
  parameter int CH_W = 4,
  parameter int AW   = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            conv_req,
  input logic            busy,
  input logic            full,
  input logic            pop,
  input logic            fifo_clr,
  input logic [AW:0]     cnt,
  input logic            irq0,
  input logic            irq1,
  input logic            iclr,
  input logic [CH_W-1:0] scan,
  input logic [CH_W-1:0] chan
);
  assert_req_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);
  assert_busy_covers_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> busy);
  assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !fifo_clr) |=> full);
  assert_reset_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (cnt == '0));
  assert_irq0_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq0 && !iclr && !fifo_clr) |=> irq0);
  assert_irq1_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq1 && !iclr && !fifo_clr) |=> irq1);
  assert_clear_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
    iclr |=> (!irq0 && !irq1));
  assert_scan_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scan <= chan);
endmodule

bind acq_trig_ctrl acq_trig_ctrl_chk #(.CH_W(CH_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .busy(busy_q), .full(full),
  .pop(pop), .fifo_clr(fifo_clr), .cnt(cnt_q), .irq0(irq_slot0), .irq1(irq_slot1),
  .iclr(wr_iclr), .scan(scan_q), .chan(chan_q)
);

// File: tb/acq_trig_ctrl_tb.sv
`timescale 1ns/1ps
module acq_trig_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] rdata, rdata12;
  logic pacer_tick = 1'b0, ext_trig = 1'b0;
  logic conv_req, conv_req12, conv_done;
  logic [3:0] conv_chan, conv_chan12;
  logic [15:0] conv_data;
  logic irq0, irq1, irq0_12, irq1_12;
  int checks = 0, fails = 0, reqs = 0, seq = 0, lat = 2;
  logic [15:0] last_data = '0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  acq_trig_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .pacer_tick(pacer_tick), .ext_trig(ext_trig),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
    .irq_slot0(irq0), .irq_slot1(irq1));

  acq_trig_ctrl #(.SAMPLE_W(12)) u_dut12 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata12), .pacer_tick(pacer_tick), .ext_trig(ext_trig),
    .conv_req(conv_req12), .conv_chan(conv_chan12), .conv_done(conv_done),
    .conv_data(conv_data[11:0]), .irq_slot0(irq0_12), .irq_slot1(irq1_12));

  // {autoscan, limit, four expected channels, expected readback}
  localparam logic [24:0] VEC [5] = '{
    {1'b1, 4'd2,  4'd0, 4'd1, 4'd2, 4'd0, 4'd1},
    {1'b1, 4'd0,  4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
    {1'b0, 4'd5,  4'd5, 4'd5, 4'd5, 4'd5, 4'd5},
    {1'b1, 4'd15, 4'd0, 4'd1, 4'd2, 4'd3, 4'd4},
    {1'b1, 4'd1,  4'd0, 4'd1, 4'd0, 4'd1, 4'd0}
  };

  initial begin
    logic [3:0] ch;
    conv_done = 1'b0; conv_data = '0;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (conv_req) begin
        reqs++;
        ch = conv_chan;
        repeat (lat) @(negedge clk);
        conv_data = {ch, seq[11:0]};
        last_data = conv_data;
        seq++;
        conv_done = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d, output logic [15:0] d12);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = rdata; d12 = rdata12;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic idle();
    repeat (lat + 5) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); pacer_tick = 1'b1;
    @(negedge clk); pacer_tick = 1'b0;
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_trig = 1'b1;
    repeat (3) @(negedge clk); ext_trig = 1'b0;
  endtask

  task automatic fifo_reset(input logic [15:0] keep);
    wr(4'h8, keep | 16'h4);
    wr(4'h8, keep);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] d, d12;
    int r0, s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h4, d, d12); chk(d == 16'h0060, "R1 status", d, 16'h0060);
    rd(4'h6, d, d12); chk(d == 16'h0000, "R1 mode", d, 0);
    chk(!irq0 && !irq1 && !conv_req, "R1 outputs", {irq0, irq1, conv_req}, 0);

    // R13 range and mode readback
    wr(4'h4, 16'h00FD);
    rd(4'h4, d, d12); chk(d[2:0] == 3'd5, "R13 range", d[2:0], 5);
    wr(4'h6, 16'h00FA);
    rd(4'h6, d, d12); chk(d == 16'h000A, "R13 mode readback", d, 16'h000A);
    wr(4'h6, 16'h0000);

    // R3 R4 channel sequencing table
    for (int i = 0; i < 5; i++) begin
      wr(4'h2, {12'd0, VEC[i][23:20]});
      wr(4'h6, {15'd0, VEC[i][24]});
      fifo_reset(16'h0);
      for (int k = 0; k < 4; k++) begin
        wr(4'hA, 16'h0);
        idle();
      end
      rd(4'h2, d, d12);
      chk(d[3:0] == VEC[i][3:0], "R4 channel readback", d[3:0], VEC[i][3:0]);
      for (int k = 0; k < 4; k++) begin
        rd(4'h0, d, d12);
        chk(d[15:12] == VEC[i][19-4*k -: 4], VEC[i][24] ? "R3 autoscan channel" : "R4 fixed channel",
            d[15:12], VEC[i][19-4*k -: 4]);
      end
    end

    // R9 sample packing
    wr(4'h2, 16'd7); wr(4'h6, 16'h0); fifo_reset(16'h0);
    wr(4'hA, 16'h0); idle();
    rd(4'h0, d, d12);
    chk(d == last_data, "R9 16-bit word", d, last_data);
    chk(d12 == {last_data[11:0], 4'h0}, "R9 12-bit word", d12, {last_data[11:0], 4'h0});

    // R5 busy and ignored trigger
    lat = 20; r0 = reqs;
    wr(4'hA, 16'h0);
    repeat (2) @(negedge clk);
    rd(4'h4, d, d12); chk(d[7] == 1'b1, "R5 busy set", d[7], 1);
    wr(4'hA, 16'h0);
    repeat (25) @(negedge clk);
    chk(reqs - r0 == 1, "R5 trigger while busy ignored", reqs - r0, 1);
    rd(4'h4, d, d12); chk(d[7:4] == 4'h7, "R5 busy clear one sample", d[7:4], 4'h7);
    rd(4'h0, d, d12);
    rd(4'h4, d, d12); chk(d[4] == 1'b0, "R6 empty after read", d[4], 0);
    lat = 2;

    // R2 trigger source selection
    r0 = reqs;
    tick(); ext_pulse(); idle();
    chk(reqs == r0, "R2 software mode ignores pacer and ext", reqs - r0, 0);
    wr(4'h6, 16'h2);
    wr(4'hA, 16'h0); idle();
    chk(reqs == r0, "R2 pacer mode ignores strobe", reqs - r0, 0);
    tick(); idle();
    chk(reqs == r0 + 1, "R2 pacer mode tick", reqs - r0, 1);
    wr(4'h6, 16'h4);
    tick(); idle();
    chk(reqs == r0 + 1, "R2 ext mode ignores pacer", reqs - r0, 1);
    @(negedge clk); ext_trig = 1'b1;
    repeat (12) @(negedge clk); ext_trig = 1'b0; idle();
    chk(reqs == r0 + 2, "R2 ext mode one edge", reqs - r0, 2);

    // R6 R7 R10 fill to full with half-full interrupt
    lat = 1;
    wr(4'h2, 16'd3); wr(4'h6, 16'h2);
    fifo_reset(16'h1);
    wr(4'hC, 16'h0);
    s0 = seq;
    for (int n = 1; n <= 1025; n++) begin
      tick();
      repeat (4) @(negedge clk);
      if (n == 511) begin
        rd(4'h4, d, d12);
        chk(d[5] == 1'b1 && !irq0, "R10 below half", {d[5], irq0}, 2);
      end
      if (n == 512) begin
        rd(4'h4, d, d12);
        chk(d[5] == 1'b0, "R6 half flag at 512", d[5], 0);
        chk(irq0 == 1'b1, "R10 half-full interrupt", irq0, 1);
      end
      if (n == 1023) begin
        rd(4'h4, d, d12); chk(d[6] == 1'b1, "R6 not full at 1023", d[6], 1);
      end
      if (n == 1024) begin
        rd(4'h4, d, d12); chk(d[6] == 1'b0, "R6 full at 1024", d[6], 0);
      end
    end
    rd(4'h4, d, d12); chk(d[6] == 1'b0, "R7 full holds", d[6], 0);
    rd(4'h0, d, d12);
    chk(d == {4'h3, 12'(s0)}, "R7 oldest first", d, {4'h3, 12'(s0)});
    rd(4'h4, d, d12); chk(d[6] == 1'b1, "R7 full drops after read", d[6], 1);
    for (int n = 1; n < 1024; n++) rd(4'h0, d, d12);
    chk(d == {4'h3, 12'(s0 + 1023)}, "R7 overflow sample dropped", d, {4'h3, 12'(s0 + 1023)});
    rd(4'h4, d, d12); chk(d[4] == 1'b0, "R6 empty after drain", d[4], 0);
    lat = 2;

    // R10 end-of-conversion source and R8 FIFO reset
    wr(4'h6, 16'h0); wr(4'h8, 16'h0); wr(4'hC, 16'h0);
    wr(4'hA, 16'h0); idle();
    chk(irq0 == 1'b1, "R10 end-of-conversion interrupt", irq0, 1);
    wr(4'hA, 16'h0); idle();
    tick(); idle();
    wr(4'h8, 16'h4); idle();
    rd(4'h4, d, d12);
    chk(d[4] == 1'b0, "R8 FIFO emptied", d[4], 0);
    chk(!irq0 && !irq1, "R8 interrupts cleared", {irq0, irq1}, 0);
    wr(4'h8, 16'h0);
    wr(4'hA, 16'h0); idle();
    rd(4'h4, d, d12); chk(d[4] == 1'b1, "R8 FIFO usable again", d[4], 1);

    // R11 slot-1 source
    wr(4'hC, 16'h0);
    tick(); idle();
    chk(irq1 == 1'b1, "R11 pacer source", irq1, 1);
    wr(4'hC, 16'h0);
    chk(irq1 == 1'b0, "R12 clear write", irq1, 0);
    ext_pulse(); idle();
    chk(irq1 == 1'b0, "R11 ext ignored with pacer source", irq1, 0);
    wr(4'h8, 16'h2);
    ext_pulse(); idle();
    chk(irq1 == 1'b1, "R11 ext source", irq1, 1);
    wr(4'hC, 16'h0);
    tick(); idle();
    chk(irq1 == 1'b0, "R11 pacer ignored with ext source", irq1, 0);

    // R12 stickiness
    wr(4'h8, 16'h0); wr(4'hC, 16'h0);
    wr(4'hA, 16'h0); idle();
    repeat (10) @(negedge clk);
    wr(4'h4, 16'h0);
    chk(irq0 == 1'b1, "R12 interrupt holds", irq0, 1);
    wr(4'hC, 16'h0);
    chk(irq0 == 1'b0, "R12 interrupt cleared", irq0, 0);

    finish_run();
  end
endmodule